// File: doc/BRIEF.md
# Descriptor List Builder for Cyclic Audio Buffers

This block turns the description of a cyclic audio buffer into a list of DMA buffer descriptors. Software gives it a base address, a total buffer length in bytes and a period length. It also sets two options: clip chunks at 4 KiB boundaries, and request a completion interrupt at the end of each period. One pulse on `start` then makes the block walk the buffer from offset zero and emit one descriptor for each chunk. Each descriptor goes out as four 32-bit words through a ready/valid memory-write port. The buffer is treated as physically contiguous.

The buffer is cut into periods. Every full period spans the programmed period length. If the buffer length is not a multiple of the period, a shorter trailing period covers what is left. A period length of zero means one period covering the whole buffer. In alignment mode a period can be split into several chunks. Only the chunk that closes a full period can carry the interrupt flag, and the trailing short period never carries it. When generation ends, the block pulses `done` and holds the number of entries written. Software programs its last-valid-index register with that count minus one. If the list would grow past its capacity, the block stops and raises `error`.

Top module: `desc_list_builder`

## Requirements
- R1: The buffer is covered by consecutive periods starting at offset 0. Each full period spans the period length. When the buffer length is not a multiple of the period length, one extra trailing period covers the remainder. Descriptor sizes add up to the buffer length unless generation stops on overflow.
- R2: A period length of 0 is treated as equal to the buffer length, which gives a single full period.
- R3: Each descriptor is written as four words at word addresses `entry*4 + k`. Word k=0 is bits [31:0] of (base + offset). Word k=1 is bits [63:32] of (base + offset). Word k=2 is the chunk size in bytes. Word k=3 is the interrupt word, either 0x1 or 0x0. Here offset is the byte offset of the chunk within the buffer.
- R4: With alignment mode on, no chunk crosses a 4 KiB boundary of the buffer offset. Each chunk size is at most 0x1000 minus offset[11:0], and the chunk is cut at exactly that point when the period extends further.
- R5: With alignment mode off, each period produces exactly one descriptor.
- R6: The interrupt word is 0x1 only on the chunk that completes a full period, and only when the interrupt enable is set. It is 0x0 on all other chunks.
- R7: The chunk or chunks of a trailing short period always carry interrupt word 0x0.
- R8: If a further entry would exceed MAX_ENTRIES, no more words are written, `error` is set and the count stays at MAX_ENTRIES. Exactly MAX_ENTRIES entries with nothing left over is not an error.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady.
- R10: `done` is high for exactly one cycle when generation ends. `entry_count` then holds the number of descriptors written. A new start clears the count and `error`.
- R11: A buffer length of 0 writes no words and finishes with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin generation; accepted only when idle |
| cfg_base | input | 64 | Buffer base address |
| cfg_buf_len | input | 32 | Total buffer length in bytes |
| cfg_period_len | input | 32 | Period length in bytes; 0 means whole buffer |
| cfg_align4k | input | 1 | Clip chunks at 4 KiB offset boundaries |
| cfg_irq_en | input | 1 | Allow interrupt flag on period-closing chunks |
| wr_valid | output | 1 | Descriptor word is valid |
| wr_ready | input | 1 | Memory accepts the word |
| wr_addr | output | $clog2(MAX_ENTRIES)+2 | Word address (entry index, word index) |
| wr_data | output | 32 | Descriptor word |
| busy | output | 1 | Generation in progress |
| done | output | 1 | One-cycle end-of-generation pulse |
| error | output | 1 | Entry limit was reached before the buffer was covered |
| entry_count | output | $clog2(MAX_ENTRIES+1) | Number of descriptors written |

## Verification
The bench goes after the cases where chunk and period boundaries do not line up. A period that straddles a 4 KiB offset boundary must split in two with the flag only on the second part. If the flag went on every chunk, or the split were based on the absolute address, the words would not match the model. A trailing short period after flagged full periods must stay unflagged; a design that flagged it would raise a spurious wakeup. A base address near a 32-bit carry checks that the high address word increments. An entry count landing exactly on the limit, and one just past it, separate a correct stop from an off-by-one that drops the last entry or overruns the list. Ready stalls check that words are neither lost nor duplicated.

// File: rtl/desc_list_pkg.sv
package desc_list_pkg;

  localparam int ADDR_W    = 64;
  localparam int LEN_W     = 32;
  localparam int WORD_W    = 32;
  localparam int PAGE_BITS = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PERIOD,
    ST_CHUNK,
    ST_WRITE,
    ST_FINISH
  } dlb_state_e;

  // Bytes left before the next 4 KiB boundary of the offset.
  function automatic logic [LEN_W-1:0] page_room(input logic [LEN_W-1:0] off);
    logic [LEN_W-1:0] low;
    low = {{(LEN_W-PAGE_BITS){1'b0}}, off[PAGE_BITS-1:0]};
    return (LEN_W'(1) << PAGE_BITS) - low;
  endfunction

  function automatic logic [LEN_W-1:0] clip_chunk(input logic [LEN_W-1:0] want,
                                                  input logic [LEN_W-1:0] off,
                                                  input logic             align);
    logic [LEN_W-1:0] room;
    room = page_room(off);
    return (align && (want > room)) ? room : want;
  endfunction

  function automatic logic [LEN_W-1:0] min_len(input logic [LEN_W-1:0] a,
                                               input logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/desc_period_calc.sv
module desc_period_calc
  import desc_list_pkg::*;
(
  input  logic [LEN_W-1:0] buf_len,
  input  logic [LEN_W-1:0] period_len,
  input  logic [LEN_W-1:0] offset,
  input  logic             irq_en,
  output logic             exhausted,
  output logic [LEN_W-1:0] span,
  output logic             span_irq
);
  logic [LEN_W-1:0] eff_period;
  logic [LEN_W-1:0] left;

  always_comb begin
    eff_period = (period_len == '0) ? buf_len : period_len;
    exhausted  = (offset >= buf_len);
    left       = exhausted ? '0 : (buf_len - offset);
    span       = min_len(eff_period, left);
    // a short tail period never gets the interrupt flag
    span_irq   = irq_en && (left >= eff_period);
  end
endmodule

// File: rtl/desc_chunk_calc.sv
module desc_chunk_calc
  import desc_list_pkg::*;
(
  input  logic [LEN_W-1:0] period_left,
  input  logic [LEN_W-1:0] offset,
  input  logic             align,
  output logic [LEN_W-1:0] chunk,
  output logic             closes_period
);
  always_comb begin
    chunk         = clip_chunk(period_left, offset, align);
    closes_period = (chunk == period_left);
  end
endmodule

// File: rtl/desc_word_sel.sv
module desc_word_sel
  import desc_list_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  offset,
  input  logic [LEN_W-1:0]  chunk,
  input  logic              ioc,
  input  logic [1:0]        word_idx,
  output logic [WORD_W-1:0] word
);
  logic [ADDR_W-1:0] chunk_addr;
  logic [WORD_W-1:0] words [4];

  assign chunk_addr = base + {{(ADDR_W-LEN_W){1'b0}}, offset};

  always_comb begin
    words[0] = chunk_addr[WORD_W-1:0];
    words[1] = chunk_addr[ADDR_W-1:WORD_W];
    words[2] = chunk;
    words[3] = {{(WORD_W-1){1'b0}}, ioc};
  end

  assign word = words[word_idx];
endmodule

// File: rtl/desc_list_builder.sv
module desc_list_builder
  import desc_list_pkg::*;
#(
  parameter int MAX_ENTRIES = 256,
  localparam int IDX_W = $clog2(MAX_ENTRIES),
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1),
  localparam int WA_W  = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [63:0]       cfg_base,
  input  logic [31:0]       cfg_buf_len,
  input  logic [31:0]       cfg_period_len,
  input  logic              cfg_align4k,
  input  logic              cfg_irq_en,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [WA_W-1:0]   wr_addr,
  output logic [31:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [CNT_W-1:0]  entry_count
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_ENTRIES);

  dlb_state_e        state;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q, per_q;
  logic              align_q, irq_q;
  logic [LEN_W-1:0]  offset_q, per_left_q, chunk_q;
  logic              per_irq_q, last_q, error_q;
  logic [1:0]        word_q;
  logic [CNT_W-1:0]  count_q;

  // named events
  logic             accept_start, word_fire, entry_fire, limit_hit;
  logic             exhausted, span_irq, closes;
  logic [LEN_W-1:0] span, chunk;

  assign accept_start = start && (state == ST_IDLE);
  assign word_fire    = wr_valid && wr_ready;
  assign entry_fire   = word_fire && (word_q == 2'd3);
  assign limit_hit    = (count_q == LIMIT);

  desc_period_calc u_period (
    .buf_len    (len_q),
    .period_len (per_q),
    .offset     (offset_q),
    .irq_en     (irq_q),
    .exhausted  (exhausted),
    .span       (span),
    .span_irq   (span_irq)
  );

  desc_chunk_calc u_chunk (
    .period_left   (per_left_q),
    .offset        (offset_q),
    .align         (align_q),
    .chunk         (chunk),
    .closes_period (closes)
  );

  desc_word_sel u_word (
    .base     (base_q),
    .offset   (offset_q),
    .chunk    (chunk_q),
    .ioc      (last_q && per_irq_q),
    .word_idx (word_q),
    .word     (wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      base_q     <= '0;
      len_q      <= '0;
      per_q      <= '0;
      align_q    <= 1'b0;
      irq_q      <= 1'b0;
      offset_q   <= '0;
      per_left_q <= '0;
      chunk_q    <= '0;
      per_irq_q  <= 1'b0;
      last_q     <= 1'b0;
      error_q    <= 1'b0;
      word_q     <= '0;
      count_q    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept_start) begin
            base_q   <= cfg_base;
            len_q    <= cfg_buf_len;
            per_q    <= cfg_period_len;
            align_q  <= cfg_align4k;
            irq_q    <= cfg_irq_en;
            offset_q <= '0;
            count_q  <= '0;
            error_q  <= 1'b0;
            state    <= ST_PERIOD;
          end
        end
        ST_PERIOD: begin
          if (exhausted) begin
            state <= ST_FINISH;
          end else begin
            per_left_q <= span;
            per_irq_q  <= span_irq;
            state      <= ST_CHUNK;
          end
        end
        ST_CHUNK: begin
          if (limit_hit) begin
            error_q <= 1'b1;
            state   <= ST_FINISH;
          end else begin
            chunk_q <= chunk;
            last_q  <= closes;
            word_q  <= '0;
            state   <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (word_fire) word_q <= word_q + 2'd1;
          if (entry_fire) begin
            offset_q   <= offset_q + chunk_q;
            per_left_q <= per_left_q - chunk_q;
            count_q    <= count_q + 1'b1;
            state      <= last_q ? ST_PERIOD : ST_CHUNK;
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign wr_valid    = (state == ST_WRITE);
  assign wr_addr     = {count_q[IDX_W-1:0], word_q};
  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_FINISH);
  assign error       = error_q;
  assign entry_count = count_q;

endmodule

// File: rtl/desc_list_builder_chk.sv
module desc_list_builder_chk #(
  parameter int MAX_ENTRIES = 256,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1),
  localparam int WA_W  = $clog2(MAX_ENTRIES) + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             error,
  input logic [CNT_W-1:0] entry_count,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [WA_W-1:0]  wr_addr,
  input logic [31:0]      wr_data,
  input logic             align_q,
  input logic [63:0]      base_q,
  input logic [31:0]      len_q
);
  logic [31:0] off_track;
  logic [63:0] exp_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_track <= '0;
    else if (start && !busy) off_track <= '0;
    else if (wr_valid && wr_ready && wr_addr[1:0] == 2'd2) off_track <= off_track + wr_data;
  end

  assign exp_addr = base_q + {32'b0, off_track};

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  overflow_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !wr_valid);

  // R8
  overflow_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && error |-> entry_count == CNT_W'(MAX_ENTRIES));

  // R6
  ioc_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr[1:0] == 2'd3 |-> wr_data[31:1] == 31'd0);

  // R4
  page_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr[1:0] == 2'd2 && align_q |->
      wr_data <= 32'h1000 - {20'd0, off_track[11:0]});

  // R3
  addr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr[1:0] == 2'd0 |-> wr_data == exp_addr[31:0]);

  // R11
  empty_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && len_q == 32'd0 |-> entry_count == '0);

endmodule

bind desc_list_builder desc_list_builder_chk #(.MAX_ENTRIES(MAX_ENTRIES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .error       (error),
  .entry_count (entry_count),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .align_q     (align_q),
  .base_q      (base_q),
  .len_q       (len_q)
);

// File: tb/desc_list_builder_test.sv
`timescale 1ns/1ps
module desc_list_builder_test;
  localparam int MAXE  = 16;
  localparam int CNT_W = $clog2(MAXE + 1);
  localparam int WA_W  = $clog2(MAXE) + 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n, start, align, irq, wr_ready;
  logic [63:0]      base;
  logic [31:0]      blen, plen;
  logic             wr_valid, busy, done, error;
  logic [WA_W-1:0]  wr_addr;
  logic [31:0]      wr_data;
  logic [CNT_W-1:0] entry_count;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  int          q_addr[$];
  logic [31:0] q_data[$];
  int          exp_count;
  bit          exp_err;

  desc_list_builder #(.MAX_ENTRIES(MAXE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(base),
    .cfg_buf_len(blen), .cfg_period_len(plen), .cfg_align4k(align),
    .cfg_irq_en(irq), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done),
    .error(error), .entry_count(entry_count)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Reference: walk the buffer and queue the expected words.
  task automatic build_model(input longint b, input longint len, input longint per,
                             input bit al, input bit ie);
    longint off = 0, peff, left, span, rem, ch, room;
    bit full, ioc;
    q_addr.delete(); q_data.delete();
    exp_count = 0; exp_err = 0;
    peff = (per == 0) ? len : per;              // R2
    while (off < len && !exp_err) begin         // R1
      left = len - off;
      span = (left < peff) ? left : peff;
      full = (left >= peff);                    // R7
      rem  = span;
      while (rem > 0) begin
        if (exp_count == MAXE) begin exp_err = 1; break; end   // R8
        ch = rem;
        room = 4096 - (off % 4096);
        if (al && ch > room) ch = room;         // R4
        rem -= ch;
        ioc = (rem == 0) && full && ie;         // R6
        q_addr.push_back(exp_count*4 + 0); q_data.push_back(32'((b + off) & 64'hFFFF_FFFF));
        q_addr.push_back(exp_count*4 + 1); q_data.push_back(32'((b + off) >> 32));
        q_addr.push_back(exp_count*4 + 2); q_data.push_back(32'(ch));
        q_addr.push_back(exp_count*4 + 3); q_data.push_back({31'd0, ioc});
        off += ch;
        exp_count++;
      end
    end
  endtask

  task automatic run_case(input string tag, input longint b, input longint len,
                          input longint per, input bit al, input bit ie, input int stall);
    int guard = 0;
    build_model(b, len, per, al, ie);
    @(negedge clk);
    base = b; blen = 32'(len); plen = 32'(per); align = al; irq = ie;
    start = 1'b1;
    forever begin
      @(negedge clk);
      start = 1'b0;
      wr_ready = (stall == 0) ? 1'b1 : ((cyc % 3) != 0);
      #1;
      guard++;
      if (wr_valid && wr_ready) begin
        if (q_addr.size() == 0) begin
          check(0, {tag, " R3 extra word"}, longint'(wr_addr), 0);
        end else begin
          check(int'(wr_addr) == q_addr[0], {tag, " R3 word address"}, longint'(wr_addr), q_addr[0]);
          check(wr_data == q_data[0], {tag, " R1/R3/R4/R6 word data"}, wr_data, q_data[0]);
          void'(q_addr.pop_front()); void'(q_data.pop_front());
        end
      end
      if (done) begin
        check(int'(entry_count) == exp_count, {tag, " R10 entry count"}, entry_count, exp_count);
        check(error == exp_err, {tag, " R8 error flag"}, error, exp_err);
        check(q_addr.size() == 0, {tag, " R1 words missing"}, q_addr.size(), 0);
        @(negedge clk); #1;
        check(done == 1'b0, {tag, " R10 done one cycle"}, done, 0);
        break;
      end
      if (guard > 20000) begin
        check(0, {tag, " R10 no done"}, 0, 1);
        break;
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; align = 1'b0; irq = 1'b0; wr_ready = 1'b0;
    base = '0; blen = '0; plen = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!busy && !done && !wr_valid && !error && entry_count == 0,
          "reset state R10", {busy, done, wr_valid, error}, 0);

    run_case("even periods R5",      64'h1000, 1000, 250, 0, 1, 0);
    run_case("tail period R7",       64'h2000, 1000, 300, 0, 1, 1);
    run_case("zero period R2 R4",    64'h0003_0000_0100, 5000, 0, 1, 1, 0);
    run_case("straddle pages R4 R6", 64'h40, 9000, 3000, 1, 1, 1);
    run_case("irq off R6",           64'h8000, 9000, 3000, 1, 0, 0);
    run_case("carry high word R3",   64'h0000_0001_FFFF_F800, 4096, 1024, 0, 1, 1);
    run_case("exact limit R8",       64'h100, 1600, 100, 0, 1, 0);
    run_case("overflow R8",          64'h100, 2000, 100, 0, 1, 1);
    run_case("restart clears R10",   64'h100, 500, 100, 0, 1, 0);
    run_case("empty buffer R11",     64'h100, 0, 100, 1, 1, 0);
    run_case("tail with align R7 R4",64'h0, 10000, 6000, 1, 1, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule